// File: doc/BRIEF.md
# Double-Buffered Complex FIR Tap Loader

This block holds the tap weights of a complex correction filter: thirteen taps for the in-phase path and thirteen for the quadrature path, each a 16-bit two's-complement word. A host reaches the taps indirectly through three small registers. The first is an auto-step enable. The second is a tap pointer that picks the bank and the tap. The third is a data port that writes or reads the tap the pointer selects.

Host writes land in a shadow copy of the taps. The filter datapath never sees the shadow copy. It uses the working copy, which is driven out in parallel on two flat buses. The whole working copy takes on the shadow contents in a single clock edge, and only when the final quadrature tap is written. A filter running during a reload therefore never mixes old and new taps. Reads through the data port return working values, so software can confirm what the filter is really using. With auto-step on, a full reload is twenty-six back-to-back data writes after one pointer write.

Top module: `coef_loader`

## Requirements
- R1: After reset the auto-step enable, the pointer, host_rdata and every shadow and working tap are zero.
- R2: The mode register sits at host address 0x0C. Bit 0 is the auto-step enable, and a read returns that bit with bits 15:1 zero.
- R3: The pointer register sits at host address 0x0D. Bit 4 selects the bank (0 in-phase, 1 quadrature) and bits 3:0 select the tap. A read returns those five bits with bits 15:5 zero.
- R4: A write to the data port at 0x0E with a tap index of 0 to 12 stores the word into the selected shadow tap. The working taps do not change unless R5 applies.
- R5: A data-port write while the pointer selects quadrature tap 12 copies all 26 shadow taps, including the word being written, into the working taps at the same clock edge.
- R6: A read of the data port returns, one cycle after the read strobe, the working tap that the pointer selects.
- R7: With a tap index of 13 to 15, data-port writes change no tap and data-port reads return zero.
- R8: With auto-step on, every data-port access advances the pointer by one tap. In-phase tap 12 and any in-phase index above 12 move to quadrature tap 0. Quadrature tap 12 and above move to in-phase tap 0. With auto-step off, data-port accesses leave the pointer unchanged.
- R9: When host_wr and host_rd are high in the same cycle, only the write takes effect. host_rdata keeps its value and the pointer steps at most once.
- R10: Reads of any other host address return zero, and writes to them change no register.
- R11: A pointer write stores the new pointer, and the auto-step rule of R8 does not apply in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one access per high cycle |
| host_rd | input | 1 | Host read strobe, one access per high cycle |
| host_addr | input | 6 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| coef_i_flat | output | 208 | Working in-phase taps, tap k at bits 16k+15:16k |
| coef_q_flat | output | 208 | Working quadrature taps, tap k at bits 16k+15:16k |

## Verification
The assertions assume that each high cycle of a strobe is one complete host access. They also assume the host never changes the pointer and the data port in the same cycle, which holds because the two share one address bus. The assertions further rely on host_rdata changing only on a read that is not masked by a write. The stimulus drives every access for exactly one cycle, changes inputs only on the falling edge, and uses a collision case for the only cycles in which both strobes are high. Random pointer values include the unused indices 13 to 15, so that the wrap and ignore rules are exercised from every bank.

// File: rtl/coef_pkg.sv
package coef_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MODE = 2'd1,
    SEL_PTR  = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  // Next pointer under auto-step: pointer carries bank at bit idx_w.
  function automatic logic [7:0] step_ptr(input logic [7:0] p,
                                          input int unsigned idx_w,
                                          input int unsigned ntaps);
    logic [7:0] mask;
    logic [7:0] idx;
    logic       bank;
    mask = (8'd1 << idx_w) - 8'd1;
    idx  = p & mask;
    bank = p[idx_w];
    if (32'(idx) + 1 < ntaps) return p + 8'd1;
    else if (bank)            return 8'd0;
    else                      return 8'd1 << idx_w;
  endfunction

  function automatic reg_sel_e decode(input logic [7:0] a,
                                      input logic [7:0] a_mode,
                                      input logic [7:0] a_ptr,
                                      input logic [7:0] a_data);
    if (a == a_mode) return SEL_MODE;
    if (a == a_ptr)  return SEL_PTR;
    if (a == a_data) return SEL_DATA;
    return SEL_NONE;
  endfunction

endpackage

// File: rtl/coef_host_regs.sv
module coef_host_regs
  import coef_pkg::*;
#(
  parameter int unsigned AW     = 6,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned NTAPS  = 13,
  parameter logic [7:0]  A_MODE = 8'h0C,
  parameter logic [7:0]  A_PTR  = 8'h0D,
  parameter logic [7:0]  A_DATA = 8'h0E,
  localparam int unsigned PW    = IDX_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic          mode_bit,
  input  logic [PW-1:0] ptr_wdata,
  output logic          autoinc,
  output logic [PW-1:0] ptr,
  output reg_sel_e      rd_sel,
  output logic          rd_fire,
  output logic          data_wr,
  output logic          data_acc
);

  reg_sel_e sel;
  logic     ptr_wr;
  logic     mode_wr;
  logic [7:0] ptr_step;

  assign sel      = decode(8'(addr), A_MODE, A_PTR, A_DATA);
  assign rd_fire  = rd && !wr;
  assign rd_sel   = rd_fire ? sel : SEL_NONE;
  assign mode_wr  = wr && (sel == SEL_MODE);
  assign ptr_wr   = wr && (sel == SEL_PTR);
  assign data_wr  = wr && (sel == SEL_DATA);
  assign data_acc = data_wr || (rd_sel == SEL_DATA);
  assign ptr_step = step_ptr(8'(ptr), IDX_W, NTAPS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      autoinc <= 1'b0;
      ptr     <= '0;
    end else begin
      if (mode_wr) autoinc <= mode_bit;
      if (ptr_wr)                   ptr <= ptr_wdata;
      else if (data_acc && autoinc) ptr <= ptr_step[PW-1:0];
    end
  end

endmodule

// File: rtl/coef_store.sv
module coef_store #(
  parameter int unsigned NTAPS = 13,
  parameter int unsigned CW    = 16,
  parameter int unsigned IDX_W = 4,
  localparam int unsigned PW   = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PW-1:0]       ptr,
  input  logic [CW-1:0]       wdata,
  output logic [NTAPS*CW-1:0] work_i,
  output logic [NTAPS*CW-1:0] work_q,
  output logic                swap
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NTAPS - 1);

  logic             bank;
  logic [IDX_W-1:0] idx;

  assign bank = ptr[IDX_W];
  assign idx  = ptr[IDX_W-1:0];
  assign swap = wr_en && bank && (idx == LAST);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
      logic [CW-1:0] shadow_q;
      logic [CW-1:0] shadow_d;
      logic          hit;
      assign hit      = wr_en && (bank == 1'(b)) && (idx == IDX_W'(t));
      assign shadow_d = hit ? wdata : shadow_q;

      always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= '0;
        else        shadow_q <= shadow_d;
      end

      if (b == 0) begin : g_i
        always_ff @(posedge clk) begin
          if (!rst_n)    work_i[t*CW +: CW] <= '0;
          else if (swap) work_i[t*CW +: CW] <= shadow_d;
        end
      end else begin : g_q
        always_ff @(posedge clk) begin
          if (!rst_n)    work_q[t*CW +: CW] <= '0;
          else if (swap) work_q[t*CW +: CW] <= shadow_d;
        end
      end
    end
  end

endmodule

// File: rtl/coef_loader.sv
module coef_loader
  import coef_pkg::*;
#(
  parameter int unsigned AW     = 6,
  parameter int unsigned CW     = 16,
  parameter int unsigned NTAPS  = 13,
  parameter logic [7:0]  A_MODE = 8'h0C,
  parameter logic [7:0]  A_PTR  = 8'h0D,
  parameter logic [7:0]  A_DATA = 8'h0E,
  localparam int unsigned IDX_W = $clog2(NTAPS),
  localparam int unsigned PW    = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [AW-1:0]       host_addr,
  input  logic [CW-1:0]       host_wdata,
  output logic [CW-1:0]       host_rdata,
  output logic [NTAPS*CW-1:0] coef_i_flat,
  output logic [NTAPS*CW-1:0] coef_q_flat
);

  logic          autoinc;
  logic [PW-1:0] ptr;
  reg_sel_e      rd_sel;
  logic          rd_fire;
  logic          data_wr;
  logic          data_acc;
  logic          swap_evt;
  logic [CW-1:0] tap_rd;
  logic [CW-1:0] rd_value;

  coef_host_regs #(
    .AW(AW), .IDX_W(IDX_W), .NTAPS(NTAPS),
    .A_MODE(A_MODE), .A_PTR(A_PTR), .A_DATA(A_DATA)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .rd(host_rd), .addr(host_addr),
    .mode_bit(host_wdata[0]), .ptr_wdata(host_wdata[PW-1:0]),
    .autoinc(autoinc), .ptr(ptr), .rd_sel(rd_sel), .rd_fire(rd_fire),
    .data_wr(data_wr), .data_acc(data_acc)
  );

  coef_store #(.NTAPS(NTAPS), .CW(CW), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .ptr(ptr), .wdata(host_wdata),
    .work_i(coef_i_flat), .work_q(coef_q_flat), .swap(swap_evt)
  );

  // Working tap addressed by the pointer; unused indices read as zero.
  always_comb begin
    tap_rd = '0;
    for (int t = 0; t < NTAPS; t++) begin
      if (ptr[IDX_W-1:0] == IDX_W'(t))
        tap_rd = ptr[IDX_W] ? coef_q_flat[t*CW +: CW] : coef_i_flat[t*CW +: CW];
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_MODE: rd_value = CW'(autoinc);
      SEL_PTR:  rd_value = CW'(ptr);
      SEL_DATA: rd_value = tap_rd;
      default:  rd_value = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       host_rdata <= '0;
    else if (rd_fire) host_rdata <= rd_value;
  end

endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
  parameter int unsigned AW     = 6,
  parameter int unsigned CW     = 16,
  parameter int unsigned NTAPS  = 13,
  parameter logic [7:0]  A_MODE = 8'h0C,
  parameter logic [7:0]  A_DATA = 8'h0E,
  localparam int unsigned IDX_W = $clog2(NTAPS),
  localparam int unsigned PW    = IDX_W + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                host_wr,
  input logic                host_rd,
  input logic [AW-1:0]       host_addr,
  input logic [CW-1:0]       host_wdata,
  input logic [CW-1:0]       host_rdata,
  input logic [NTAPS*CW-1:0] coef_i_flat,
  input logic [NTAPS*CW-1:0] coef_q_flat,
  input logic [PW-1:0]       ptr,
  input logic                autoinc,
  input logic                data_acc,
  input logic                swap_evt
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NTAPS - 1);
  localparam logic [PW-1:0]    Q_LAST = {1'b1, LAST};
  localparam logic [PW-1:0]    I_LAST = {1'b0, LAST};
  localparam logic [PW-1:0]    Q_FIRST = {1'b1, {IDX_W{1'b0}}};

  logic wr_ptr;
  assign wr_ptr = host_wr && (8'(host_addr) == A_DATA - 8'd1);

  p_work_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_evt |=> ($stable(coef_i_flat) && $stable(coef_q_flat)));

  p_swap_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> (coef_q_flat[(NTAPS-1)*CW +: CW] == $past(host_wdata)));

  p_swap_when_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && 8'(host_addr) == A_DATA && ptr == Q_LAST) |-> swap_evt);

  p_wrap_q_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && autoinc && ptr == Q_LAST) |=> (ptr == '0));

  p_cross_i_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && autoinc && ptr == I_LAST) |=> (ptr == Q_FIRST));

  p_no_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!autoinc && !wr_ptr) |=> $stable(ptr));

  p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> $stable(host_rdata));

  p_bad_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && 8'(host_addr) == A_DATA && ptr[IDX_W-1:0] > LAST)
      |=> (host_rdata == '0));

  p_mode_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && 8'(host_addr) == A_MODE)
      |=> (host_rdata[CW-1:1] == '0));

endmodule

bind coef_loader coef_loader_chk #(
  .AW(AW), .CW(CW), .NTAPS(NTAPS), .A_MODE(A_MODE), .A_DATA(A_DATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .coef_i_flat(coef_i_flat), .coef_q_flat(coef_q_flat), .ptr(ptr),
  .autoinc(autoinc), .data_acc(data_acc), .swap_evt(swap_evt)
);

// File: tb/sim_coef_loader.sv
module sim_coef_loader;

  localparam logic [5:0] AM = 6'h0C, AP = 6'h0D, AD = 6'h0E;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         host_wr = 1'b0, host_rd = 1'b0;
  logic [5:0]   host_addr = '0;
  logic [15:0]  host_wdata = '0;
  logic [15:0]  host_rdata;
  logic [207:0] coef_i_flat, coef_q_flat;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [15:0] mi[13], mq[13], si[13], sq[13];
  logic        m_mode;
  logic [4:0]  m_ptr;
  logic [15:0] m_rdata;

  always #10 clk = ~clk;

  coef_loader u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Linear walk through 26 taps; unused indices jump to the other bank start.
  function automatic logic [4:0] model_next(input logic [4:0] p);
    int pos;
    if (p[3:0] > 4'd12) return p[4] ? 5'd0 : 5'd16;
    pos = (p[4] ? 13 : 0) + int'(p[3:0]) + 1;
    if (pos == 26) pos = 0;
    return (pos >= 13) ? 5'(16 + pos - 13) : 5'(pos);
  endfunction

  function automatic logic [15:0] model_tap(input logic [4:0] p);
    if (p[3:0] > 4'd12) return 16'h0;
    return p[4] ? sq[p[3:0]] : si[p[3:0]];
  endfunction

  task automatic check_outputs(input string tag);
    bit ok = 1;
    for (int k = 0; k < 13; k++)
      if (coef_i_flat[k*16 +: 16] !== si[k] || coef_q_flat[k*16 +: 16] !== sq[k]) ok = 0;
    chk(ok, tag, coef_q_flat[12*16 +: 16], sq[12]);
  endtask

  task automatic hwrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
    if (a == AM) m_mode = d[0];
    else if (a == AP) m_ptr = d[4:0];
    else if (a == AD) begin
      if (m_ptr[3:0] <= 4'd12) begin
        if (m_ptr[4]) mq[m_ptr[3:0]] = d; else mi[m_ptr[3:0]] = d;
      end
      if (m_ptr == 5'd28) begin
        si = mi; sq = mq;
      end
      if (m_mode) m_ptr = model_next(m_ptr);
    end
  endtask

  task automatic hread(input logic [5:0] a, input string tag);
    logic [15:0] e;
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0;
    if (a == AM) e = {15'b0, m_mode};
    else if (a == AP) e = {11'b0, m_ptr};
    else if (a == AD) e = model_tap(m_ptr);
    else e = 16'h0;
    chk(host_rdata === e, tag, host_rdata, e);
    m_rdata = e;
    if (a == AD && m_mode) m_ptr = model_next(m_ptr);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 13; k++) begin mi[k] = 0; mq[k] = 0; si[k] = 0; sq[k] = 0; end
    m_mode = 0; m_ptr = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(host_rdata === 16'h0, "R1 rdata", host_rdata, 16'h0);
    check_outputs("R1 working taps");
    hread(AM, "R1 R2 mode");
    hread(AP, "R1 R3 pointer");

    // R2 / R3 field widths
    hwrite(AM, 16'hFFFF);
    hread(AM, "R2 mode bit only");
    hwrite(AM, 16'h0000);
    hwrite(AP, 16'hFFF3);
    hread(AP, "R3 pointer bits");

    // R4 shadow write not visible
    hwrite(AP, 16'h0003);
    hwrite(AD, 16'hBEEF);
    check_outputs("R4 working unchanged");
    hread(AD, "R4 R6 still old");
    hread(AP, "R8 no step when off");

    // R5 full reload with auto-step
    hwrite(AM, 16'h0001);
    hwrite(AP, 16'h0000);
    for (int k = 0; k < 26; k++) begin
      hwrite(AD, 16'($urandom));
      if (k == 24) check_outputs("R5 no transfer before last");
    end
    check_outputs("R5 transfer on last Q");
    hread(AP, "R8 wrap to I0");
    for (int k = 0; k < 26; k++) hread(AD, "R6 readback");
    hread(AP, "R8 read wrap");

    // R7 unused index
    hwrite(AP, 16'h001E);
    hwrite(AD, 16'h1234);
    hread(AP, "R8 Q invalid to I0");
    hwrite(AP, 16'h000D);
    hread(AD, "R7 invalid reads zero");
    hread(AP, "R8 I invalid to Q0");
    hwrite(AM, 16'h0000);
    hwrite(AP, 16'h001C);
    hwrite(AD, 16'h5A5A);
    check_outputs("R5 R7 reload after invalid writes");

    // R10 unmapped
    hwrite(6'h3F, 16'hFFFF);
    hread(6'h3F, "R10 unmapped read");
    hread(AM, "R10 mode untouched");
    hread(AP, "R10 ptr untouched");

    // R9 collision
    hread(AP, "R9 prime");
    @(negedge clk); host_wr = 1; host_rd = 1; host_addr = AP; host_wdata = 16'h0012;
    @(negedge clk); host_wr = 0; host_rd = 0;
    chk(host_rdata === m_rdata, "R9 rdata held", host_rdata, m_rdata);
    m_ptr = 5'h12;
    hread(AP, "R9 R11 write took effect");

    // R11 pointer write under auto-step
    hwrite(AM, 16'h0001);
    hwrite(AP, 16'h0005);
    hread(AP, "R11 pointer not stepped");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned op = $urandom_range(0, 9);
      case (op)
        0: hwrite(AM, 16'($urandom));
        1: hwrite(AP, 16'($urandom_range(0, 31)));
        2, 3, 4: hwrite(AD, 16'($urandom));
        5: hread(AD, "R6 random read");
        6: hread(AP, "R8 random pointer");
        7: hread(AM, "R2 random mode");
        8: hwrite(AP, 16'h001C);
        default: hread(6'(32'h20 + $urandom_range(0, 31)), "R10 random unmapped");
      endcase
      check_outputs("R4 R5 random working set");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule